// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each data beat of one burst in a synchronous DRAM. A read or write command supplies a start column. The block then gives out one column per clock until the burst is complete. The mode register supplies two settings. A burst-length code selects one, two, four or eight beats, or a full-page burst. A wrap bit selects the beat ordering.

In a fixed-length burst the address stays inside an aligned block of the burst length. The high column bits stay the same. The low bits either count upward and wrap inside the block (sequential ordering), or they are the start bits XORed with the beat index (interleave ordering). A full-page burst counts through the whole row and wraps from the last column back to column zero. It continues until the terminate input ends it. A new start can arrive on any clock. It discards the current burst and starts the new one. The column width is a parameter: 11 bits for the x4 organisation, 10 for x8 and 9 for x16.

Inside the block a three-state machine controls the burst. IDLE means no burst is running. FIXED means a fixed-length burst is running. PAGE means a full-page burst is running. These are the transitions:
- start: from any state to FIXED, or to PAGE when the code selects a full page.
- done: from FIXED to IDLE after the last beat.
- stop: from FIXED or PAGE to IDLE when terminate is sampled.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low, and after reset is released until the first start, `valid_o` and `last_o` are low and `col_o` is zero.
- R2: When `start_i` is sampled high at a clock edge, the outputs after that edge show beat 0: `valid_o` is high and `col_o` equals `start_col_i`. The burst-length codes on `bl_code_i` are: 0 gives one beat, 1 gives two, 2 gives four, 3 gives eight, and 7 gives a full page. Codes 4, 5 and 6 give one beat.
- R3: A one-beat burst shows a single beat with `last_o` high. `valid_o` is low in the next cycle unless a new start is sampled.
- R4: With `wrap_il_i` = 0 and a fixed burst length BL, the low log2(BL) bits of beat n are (start low bits + n) mod BL. The higher bits equal those of the start column.
- R5: With `wrap_il_i` = 1 and a fixed burst length BL, the low log2(BL) bits of beat n are the start low bits XOR n. The higher bits equal those of the start column.
- R6: `last_o` is high only on beat BL-1 of a fixed-length burst. `valid_o` falls after that beat unless a new start is sampled.
- R7: In a full-page burst, beat n is (start + n) mod 2^COL_W. `wrap_il_i` has no effect in this mode, `last_o` stays low, and the burst runs until it is terminated.
- R8: When `stop_i` is sampled high during a burst, `valid_o` is low in the next cycle. When no burst is running, `stop_i` has no effect.
- R9: A start sampled during a burst replaces that burst, and the next cycle shows beat 0 of the new burst. When `start_i` and `stop_i` are high together, the start takes effect.
- R10: `start_col_i`, `bl_code_i` and `wrap_il_i` are sampled only with a start. Changing them during a burst does not change the burst.
- R11: Whenever `valid_o` is low, `col_o` is zero and `last_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst at this edge |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Burst-length code |
| wrap_il_i | input | 1 | 1 = interleave ordering, 0 = sequential ordering |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with COL_W = 9, which is the x16 row of 512 columns. This makes a full-page burst that wraps past the end of the row short enough to run to completion, and the bench does so from a start near the top of the row. With nine bits there are also high column bits above the eight-beat block, so the bench can see whether they stay fixed during a burst. Its start columns put the low bits mid-block, so that both the sequential wrap and the interleave XOR give orderings that differ from a plain count.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_e;

    localparam logic [2:0] BLC_ONE  = 3'd0;
    localparam logic [2:0] BLC_TWO  = 3'd1;
    localparam logic [2:0] BLC_FOUR = 3'd2;
    localparam logic [2:0] BLC_EIGHT = 3'd3;
    localparam logic [2:0] BLC_PAGE = 3'd7;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [2:0]       bl_code_i,
    output logic [COL_W-1:0] span_mask_o,
    output logic             page_o
);

    always_comb begin
        span_mask_o = '0;
        page_o      = 1'b0;
        unique case (bl_code_i)
            BLC_TWO:   span_mask_o = COL_W'(1);
            BLC_FOUR:  span_mask_o = COL_W'(3);
            BLC_EIGHT: span_mask_o = COL_W'(7);
            BLC_PAGE: begin
                span_mask_o = '1;
                page_o      = 1'b1;
            end
            default:   span_mask_o = '0;
        endcase
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] span_mask_i,
    input  logic             page_i,
    input  logic             wrap_il_i,
    output logic             active_o,
    output logic             in_page_o,
    output logic             final_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_col_o,
    output logic [COL_W-1:0] mask_o,
    output logic             il_o
);

    burst_state_e state_q, state_nx;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             il_q;
    logic             at_end;

    assign at_end = (beat_q == mask_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state: start wins over stop and over the end of a burst
    always_comb begin
        state_nx = state_q;
        if (start_i) begin
            state_nx = page_i ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_FIXED: if (stop_i || at_end) state_nx = ST_IDLE;
                ST_PAGE:  if (stop_i) state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // burst context captured at start, beat index advancing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            base_q <= '0;
            mask_q <= '0;
            il_q   <= 1'b0;
        end else if (start_i) begin
            beat_q <= '0;
            base_q <= start_col_i;
            mask_q <= span_mask_i;
            il_q   <= wrap_il_i & ~page_i;
        end else if (state_q != ST_IDLE) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        active_o   = 1'b0;
        in_page_o  = 1'b0;
        final_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  active_o = 1'b0;
            ST_FIXED: begin
                active_o = 1'b1;
                final_o  = at_end;
            end
            ST_PAGE: begin
                active_o  = 1'b1;
                in_page_o = 1'b1;
            end
            default:  active_o = 1'b0;
        endcase
        beat_o     = beat_q;
        base_col_o = base_q;
        mask_o     = mask_q;
        il_o       = il_q;
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 11
) (
    input  logic             active_i,
    input  logic             il_i,
    input  logic [COL_W-1:0] base_col_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] merged;

    assign seq_sum = base_col_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask_i[b]) begin
                merged[b] = base_col_i[b];
            end else if (il_i) begin
                merged[b] = base_col_i[b] ^ beat_i[b];
            end else begin
                merged[b] = seq_sum[b];
            end
        end
    end

    assign col_o = active_i ? merged : '0;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             wrap_il_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    logic [COL_W-1:0] span_mask;
    logic             page_sel;
    logic             active;
    logic             in_page;
    logic             final_beat;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] mask;
    logic             il;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .bl_code_i   (bl_code_i),
        .span_mask_o (span_mask),
        .page_o      (page_sel)
    );

    burst_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .span_mask_i (span_mask),
        .page_i      (page_sel),
        .wrap_il_i   (wrap_il_i),
        .active_o    (active),
        .in_page_o   (in_page),
        .final_o     (final_beat),
        .beat_o      (beat),
        .base_col_o  (base_col),
        .mask_o      (mask),
        .il_o        (il)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_addr (
        .active_i   (active),
        .il_i       (il & ~in_page),
        .base_col_i (base_col),
        .beat_i     (beat),
        .mask_i     (mask),
        .col_o      (col_o)
    );

    assign valid_o = active;
    assign last_o  = final_beat;

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
    parameter int COL_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);

    assert_burst_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i) |=> valid_o);

    assert_col_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i) |=> (col_o != $past(col_o)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0 && !last_o));

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] start_col_i = '0;
    logic [2:0]   bl_code_i = '0;
    logic         wrap_il_i = 1'b0;
    logic         stop_i = 1'b0;
    logic [W-1:0] col_o;
    logic         valid_o;
    logic         last_o;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(W)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .start_col_i (start_col_i), .bl_code_i (bl_code_i),
        .wrap_il_i (wrap_il_i), .stop_i (stop_i),
        .col_o (col_o), .valid_o (valid_o), .last_o (last_o)
    );

    typedef struct packed {
        logic         v;
        logic [W-1:0] c;
        logic         l;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    driver_done = 1'b0;

    // reference state
    bit m_act = 0;
    bit m_pg  = 0;
    bit m_il  = 0;
    int m_s   = 0;
    int m_n   = 0;
    int m_len = 1;

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_col();
        int off;
        if (m_pg) return W'((m_s + m_n) % (1 << W));
        off = m_s % m_len;
        if (m_il) return W'((m_s - off) + (off ^ m_n));
        return W'((m_s - off) + ((off + m_n) % m_len));
    endfunction

    task automatic step(input logic st, input logic [W-1:0] c, input logic [2:0] code,
                        input logic il, input logic sp, input string tag);
        exp_t e;
        @(negedge clk);
        start_i = st; start_col_i = c; bl_code_i = code; wrap_il_i = il; stop_i = sp;
        if (st) begin
            m_act = 1; m_n = 0; m_s = int'(c); m_pg = (code == 3'd7);
            m_len = len_of(code); m_il = il;
        end else if (m_act) begin
            if (sp) m_act = 0;
            else if (!m_pg && m_n == m_len - 1) m_act = 0;
            else m_n = m_pg ? (m_n + 1) % (1 << W) : m_n + 1;
        end
        e.v = m_act;
        e.c = m_act ? ref_col() : '0;
        e.l = m_act && !m_pg && (m_n == m_len - 1);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 3'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic burst(input logic [W-1:0] c, input logic [2:0] code, input logic il,
                         input int beats, input string tag);
        step(1'b1, c, code, il, 1'b0, tag);
        idle(beats, tag);
    endtask

    // monitor: compare outputs 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (valid_o !== e.v || col_o !== e.c || last_o !== e.l) begin
                n_bad++;
                $display("FAIL %s: got valid=%0b col=%0h last=%0b, expected valid=%0b col=%0h last=%0b",
                         t, valid_o, col_o, last_o, e.v, e.c, e.l);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got no end of run, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
            n_bad++;
            $display("FAIL R1: got valid=%0b col=%0h last=%0b, expected 0 0 0", valid_o, col_o, last_o);
        end
        @(negedge clk); rst_n = 1'b1;
        idle(2, "R1 idle after reset");
        // R8: stop while idle
        step(1'b0, '0, 3'd0, 1'b0, 1'b1, "R8 stop idle");
        // R4/R6: sequential eight, mid-block start, high bits set
        burst(9'h0A5, 3'd3, 1'b0, 9, "R4 R6 seq8");
        // R5: interleave eight
        burst(9'h0A5, 3'd3, 1'b1, 9, "R5 il8");
        // R4: sequential four, R5 interleave two, four
        burst(9'h13E, 3'd2, 1'b0, 5, "R4 seq4");
        burst(9'h13B, 3'd1, 1'b1, 3, "R5 il2");
        burst(9'h1F6, 3'd2, 1'b1, 5, "R5 il4");
        // R3: one beat, and reserved code
        burst(9'h07F, 3'd0, 1'b1, 2, "R3 one beat");
        burst(9'h0C3, 3'd5, 1'b0, 2, "R2 R3 reserved code");
        // R6: back-to-back bursts, start on the last beat
        step(1'b1, 9'h010, 3'd1, 1'b0, 1'b0, "R6 b2b");
        step(1'b0, '0, 3'd0, 1'b0, 1'b0, "R6 b2b");
        burst(9'h021, 3'd1, 1'b0, 3, "R6 b2b second");
        // R8: stop in the middle of an eight-beat burst
        burst(9'h040, 3'd3, 1'b0, 3, "R8 stop mid");
        step(1'b0, '0, 3'd0, 1'b0, 1'b1, "R8 stop mid");
        idle(2, "R8 after stop");
        // R9: restart mid burst, start with stop
        burst(9'h080, 3'd3, 1'b1, 2, "R9 restart");
        step(1'b1, 9'h1C6, 3'd2, 1'b0, 1'b1, "R9 start beats stop");
        idle(5, "R9 new burst");
        // R10: inputs changed mid burst
        step(1'b1, 9'h103, 3'd3, 1'b0, 1'b0, "R10 sampled once");
        for (int i = 0; i < 8; i++)
            step(1'b0, W'(i * 37), 3'(i), i[0], 1'b0, "R10 sampled once");
        idle(1, "R10 end");
        // R7: full page wrapping past the row end, interleave bit ignored
        step(1'b1, 9'h1FD, 3'd7, 1'b1, 1'b0, "R7 page");
        idle(520, "R7 page wrap");
        step(1'b0, '0, 3'd0, 1'b0, 1'b1, "R7 R8 page stop");
        idle(3, "R11 idle");
        driver_done = 1'b1;
    end

    initial begin
        wait (driver_done);
        wait (exp_q.size() == 0);
        @(posedge clk); #3;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule